// File: doc/BRIEF.md
# Page Redirection Chain Resolver

This block turns a logical page number (0 to 63) of a one-time-programmable memory into the physical page that holds that page's current data. Each page has one replacement byte in status memory. Erased cells read as all ones, and bits can only be cleared. A page that has been replaced therefore holds the bitwise inverse of its successor's number. An erased byte (FFh) inverts to zero and means the page has not been replaced.

The resolver walks the chain of replacement bytes through a synchronous read port with one cycle of read latency. It stops at the first page that has not been replaced. It then reads the protect byte that covers that page's replacement entry and reports whether the entry is locked. Two conditions stop the walk and raise a fault: a replacement byte that decodes beyond the last page, and a chain that loops.

The result appears with a one-cycle done pulse. The result stays on the outputs until the next request completes. The block only reads memory; it never writes it.

Top module: `page_chain_resolver`

## Requirements
- R1: Each chain step issues one read at status address 100h plus the current page, holding `rd_en_o` high for exactly one cycle. The data is used in the following cycle, so one step takes two cycles.
- R2: A replacement byte of FFh ends the walk, and `page_o` reports the page whose byte was read.
- R3: For any other byte whose inverse lies in 1..63 and differs from the start page, the walk moves to that inverse and continues, across any number of steps.
- R4: A byte whose inverse exceeds 63 stops the walk. The top two bits are then not both 1. `fault_o` is set, `loop_o` is clear, and `page_o` is the page whose byte was read.
- R5: A byte whose inverse equals the start page stops the walk with `loop_o` set and `page_o` equal to the page whose byte was read.
- R6: The walk stops with `loop_o` set when a 64th step would be followed. `page_o` is then the page whose byte was read in the 64th read.
- R7: After the chain reads, the block reads one protect byte at status address 020h plus page bits [5:3]. `locked_o` is 1 when bit [2:0] of that byte, for the final page, is 0.
- R8: `done_o` is high for exactly one cycle, 2·N+2 clock edges after the edge that samples `start_i`, where N is the number of chain reads. The outputs hold their values until the next done.
- R9: `start_i` is ignored while a walk is in progress. The result of the running walk is unchanged.
- R10: After reset, `done_o`, `rd_en_o`, `page_o`, `fault_o`, `loop_o` and `locked_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a lookup (sampled while idle) |
| page_i | input | 6 | Logical page to resolve |
| rd_en_o | output | 1 | Status memory read strobe |
| rd_addr_o | output | 9 | Status memory read address |
| rd_data_i | input | 8 | Status memory read data, valid the cycle after the strobe |
| done_o | output | 1 | One-cycle completion pulse |
| page_o | output | 6 | Resolved physical page |
| fault_o | output | 1 | Replacement byte decoded out of range |
| loop_o | output | 1 | Chain looped or exceeded the step limit |
| locked_o | output | 1 | Final page's replacement entry is write-protected |

## Verification
The hardest case to reach is the step limit. It needs a loop that never passes through the start page, so the start-page check never fires and only the step counter can end the walk. The bench builds a two-page cycle behind a separate entry page. It then confirms that exactly 64 chain reads occur and that the reported page is the one read in the 64th read. A second hard case is a start request during a walk. The bench pulses `start_i` with a different page in the middle of a multi-step chain and checks that the original chain's result and timing are unchanged.

// File: rtl/page_chain_pkg.sv
package page_chain_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_REQ = 3'd1,
    ST_RD_CAP = 3'd2,
    ST_LK_REQ = 3'd3,
    ST_LK_CAP = 3'd4
  } walk_state_e;

  typedef enum logic [1:0] {
    HOP_END    = 2'd0,
    HOP_RANGE  = 2'd1,
    HOP_ORIGIN = 2'd2,
    HOP_FOLLOW = 2'd3
  } hop_kind_e;

endpackage

// File: rtl/redir_decode.sv
module redir_decode
  import page_chain_pkg::*;
#(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic [PAGE_W-1:0] origin_i,
  output hop_kind_e         kind_o,
  output logic [PAGE_W-1:0] target_o
);

  logic [DATA_W-1:0] inv;

  always_comb begin
    inv      = ~entry_i;
    target_o = inv[PAGE_W-1:0];
    if (inv == '0) begin
      kind_o = HOP_END;
    end else if ((inv >> PAGE_W) != '0) begin
      kind_o = HOP_RANGE;
    end else if (inv[PAGE_W-1:0] == origin_i) begin
      kind_o = HOP_ORIGIN;
    end else begin
      kind_o = HOP_FOLLOW;
    end
  end

endmodule

// File: rtl/hop_counter.sv
module hop_counter #(
  parameter int MAX_HOPS = 64,
  localparam int HOP_W = $clog2(MAX_HOPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [HOP_W-1:0] count_o,
  output logic             last_o
);

  logic [HOP_W-1:0] cnt_q;
  logic [HOP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + HOP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == HOP_W'(MAX_HOPS - 1));

endmodule

// File: rtl/status_addr_gen.sv
module status_addr_gen #(
  parameter int              PAGE_W     = 6,
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 9,
  parameter logic [ADDR_W-1:0] REDIR_BASE = 9'h100,
  parameter logic [ADDR_W-1:0] LOCK_BASE  = 9'h020
) (
  input  logic              lock_sel_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int BIT_SEL_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] redir_addr;
  logic [ADDR_W-1:0] lock_addr;

  always_comb begin
    redir_addr = REDIR_BASE + ADDR_W'(page_i);
    lock_addr  = LOCK_BASE + ADDR_W'(page_i >> BIT_SEL_W);
    addr_o     = lock_sel_i ? lock_addr : redir_addr;
  end

endmodule

// File: rtl/page_chain_resolver.sv
module page_chain_resolver
  import page_chain_pkg::*;
#(
  parameter int                PAGE_W     = 6,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 9,
  parameter logic [ADDR_W-1:0] REDIR_BASE = 9'h100,
  parameter logic [ADDR_W-1:0] LOCK_BASE  = 9'h020,
  parameter int                MAX_HOPS   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              done_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              fault_o,
  output logic              loop_o,
  output logic              locked_o
);

  localparam int BIT_SEL_W = $clog2(DATA_W);
  localparam int HOP_W     = $clog2(MAX_HOPS + 1);

  walk_state_e       state_q, state_d;
  logic [PAGE_W-1:0] cur_q, cur_d;
  logic [PAGE_W-1:0] origin_q, origin_d;
  logic              pend_fault_q, pend_fault_d;
  logic              pend_loop_q, pend_loop_d;
  logic              walk_en;

  logic [PAGE_W-1:0] res_page_q, res_page_d;
  logic              res_fault_q, res_fault_d;
  logic              res_loop_q, res_loop_d;
  logic              res_lock_q, res_lock_d;
  logic              res_en;
  logic              done_q, done_d;

  hop_kind_e         kind;
  logic [PAGE_W-1:0] target;
  logic              hop_clr, hop_inc, hop_last;
  logic [HOP_W-1:0]  hop_count;
  logic [BIT_SEL_W-1:0] bit_sel;

  redir_decode #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_decode (
    .entry_i  (rd_data_i),
    .origin_i (origin_q),
    .kind_o   (kind),
    .target_o (target)
  );

  hop_counter #(.MAX_HOPS(MAX_HOPS)) u_hops (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (hop_clr),
    .inc_i   (hop_inc),
    .count_o (hop_count),
    .last_o  (hop_last)
  );

  status_addr_gen #(
    .PAGE_W(PAGE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .REDIR_BASE(REDIR_BASE), .LOCK_BASE(LOCK_BASE)
  ) u_addr (
    .lock_sel_i (state_q == ST_LK_REQ),
    .page_i     (cur_q),
    .addr_o     (rd_addr_o)
  );

  assign bit_sel = cur_q[BIT_SEL_W-1:0];

  // Walk control: next-state logic
  always_comb begin
    state_d      = state_q;
    cur_d        = cur_q;
    origin_d     = origin_q;
    pend_fault_d = pend_fault_q;
    pend_loop_d  = pend_loop_q;
    walk_en      = 1'b0;
    hop_clr      = 1'b0;
    hop_inc      = 1'b0;
    res_en       = 1'b0;
    res_page_d   = res_page_q;
    res_fault_d  = res_fault_q;
    res_loop_d   = res_loop_q;
    res_lock_d   = res_lock_q;
    done_d       = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          walk_en      = 1'b1;
          state_d      = ST_RD_REQ;
          cur_d        = page_i;
          origin_d     = page_i;
          pend_fault_d = 1'b0;
          pend_loop_d  = 1'b0;
          hop_clr      = 1'b1;
        end
      end
      ST_RD_REQ: begin
        walk_en = 1'b1;
        state_d = ST_RD_CAP;
      end
      ST_RD_CAP: begin
        walk_en = 1'b1;
        state_d = ST_LK_REQ;
        unique case (kind)
          HOP_END:    ;
          HOP_RANGE:  pend_fault_d = 1'b1;
          HOP_ORIGIN: pend_loop_d  = 1'b1;
          HOP_FOLLOW: begin
            if (hop_last) begin
              pend_loop_d = 1'b1;
            end else begin
              hop_inc = 1'b1;
              cur_d   = target;
              state_d = ST_RD_REQ;
            end
          end
          default: ;
        endcase
      end
      ST_LK_REQ: begin
        walk_en = 1'b1;
        state_d = ST_LK_CAP;
      end
      ST_LK_CAP: begin
        walk_en     = 1'b1;
        state_d     = ST_IDLE;
        res_en      = 1'b1;
        res_page_d  = cur_q;
        res_fault_d = pend_fault_q;
        res_loop_d  = pend_loop_q;
        res_lock_d  = ~rd_data_i[bit_sel];
        done_d      = 1'b1;
      end
      default: begin
        walk_en = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  // Walk control: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_q        <= '0;
      origin_q     <= '0;
      pend_fault_q <= 1'b0;
      pend_loop_q  <= 1'b0;
    end else if (walk_en) begin
      state_q      <= state_d;
      cur_q        <= cur_d;
      origin_q     <= origin_d;
      pend_fault_q <= pend_fault_d;
      pend_loop_q  <= pend_loop_d;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_page_q  <= '0;
      res_fault_q <= 1'b0;
      res_loop_q  <= 1'b0;
      res_lock_q  <= 1'b0;
    end else if (res_en) begin
      res_page_q  <= res_page_d;
      res_fault_q <= res_fault_d;
      res_loop_q  <= res_loop_d;
      res_lock_q  <= res_lock_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign rd_en_o  = (state_q == ST_RD_REQ) || (state_q == ST_LK_REQ);
  assign done_o   = done_q;
  assign page_o   = res_page_q;
  assign fault_o  = res_fault_q;
  assign loop_o   = res_loop_q;
  assign locked_o = res_lock_q;

endmodule

// File: rtl/page_chain_resolver_chk.sv
module page_chain_resolver_chk #(
  parameter int PAGE_W = 6,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o,
  input logic [PAGE_W-1:0] page_o,
  input logic              fault_o,
  input logic              loop_o,
  input logic              locked_o
);

  // R1
  rd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o);

  // R1
  rd_addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> ((rd_addr_o >= ADDR_W'(9'h100) && rd_addr_o <= ADDR_W'(9'h13F)) ||
                 (rd_addr_o >= ADDR_W'(9'h020) && rd_addr_o <= ADDR_W'(9'h027))));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_after_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !rd_en_o && $past(rd_en_o, 2));

  // R4
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(fault_o && loop_o));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || ($stable(page_o) && $stable(fault_o) &&
                            $stable(loop_o) && $stable(locked_o))));

endmodule

bind page_chain_resolver page_chain_resolver_chk #(
  .PAGE_W(PAGE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rd_en_o   (rd_en_o),
  .rd_addr_o (rd_addr_o),
  .done_o    (done_o),
  .page_o    (page_o),
  .fault_o   (fault_o),
  .loop_o    (loop_o),
  .locked_o  (locked_o)
);

// File: tb/page_chain_resolver_tb.sv
`timescale 1ns/1ps
module page_chain_resolver_tb;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [5:0] page_i;
  logic       rd_en_o;
  logic [8:0] rd_addr_o;
  logic [7:0] rd_data_i;
  logic       done_o;
  logic [5:0] page_o;
  logic       fault_o;
  logic       loop_o;
  logic       locked_o;

  logic [7:0] mem [0:511];
  int         n_chk;
  int         n_bad;
  int         redir_reads;
  logic [8:0] last_redir_addr;
  int         lat;
  int         reads;

  page_chain_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_i(page_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .done_o(done_o), .page_o(page_o), .fault_o(fault_o), .loop_o(loop_o),
    .locked_o(locked_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en_o) begin
      rd_data_i <= mem[rd_addr_o];
      if (rd_addr_o >= 9'h100) begin
        redir_reads     <= redir_reads + 1;
        last_redir_addr <= rd_addr_o;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
  endtask

  // Launch a lookup and wait for done; lat counts negedges, reads counts chain reads
  task automatic run(input logic [5:0] pg);
    int r0;
    r0 = redir_reads;
    @(negedge clk);
    page_i  = pg;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    if (!done_o) check("watchdog", 0, 1);
    reads = redir_reads - r0;
  endtask

  task automatic t_reset();
    check("R10 done", done_o, 0);
    check("R10 rd_en", rd_en_o, 0);
    check("R10 page", page_o, 0);
    check("R10 fault", fault_o, 0);
    check("R10 loop", loop_o, 0);
    check("R10 locked", locked_o, 0);
  endtask

  task automatic t_direct();
    clear_mem();
    run(6'd7);
    check("R2 page", page_o, 7);
    check("R2 fault", fault_o, 0);
    check("R2 loop", loop_o, 0);
    check("R1 reads", reads, 1);
    check("R1 addr", last_redir_addr, 9'h107);
    check("R8 latency", lat, 2 * 1 + 3);
    check("R7 unlocked", locked_o, 0);
  endtask

  task automatic t_chain();
    clear_mem();
    mem[9'h100 + 10] = ~8'd20;
    mem[9'h100 + 20] = ~8'd33;
    mem[9'h020 + 4]  = 8'hFD;     // page 33: byte 4, bit 1 cleared
    run(6'd10);
    check("R3 page", page_o, 33);
    check("R3 reads", reads, 3);
    check("R8 latency", lat, 2 * 3 + 3);
    check("R7 locked", locked_o, 1);
    @(negedge clk);
    check("R8 pulse", done_o, 0);
    @(negedge clk);
    check("R8 hold", page_o, 33);
  endtask

  task automatic t_range();
    clear_mem();
    mem[9'h100 + 12] = 8'h3F;
    run(6'd12);
    check("R4 fault", fault_o, 1);
    check("R4 loop", loop_o, 0);
    check("R4 page", page_o, 12);
  endtask

  task automatic t_origin();
    clear_mem();
    mem[9'h100 + 5] = ~8'd9;
    mem[9'h100 + 9] = ~8'd5;
    run(6'd5);
    check("R5 loop", loop_o, 1);
    check("R5 fault", fault_o, 0);
    check("R5 page", page_o, 9);
    mem[9'h100 + 4] = ~8'd4;
    run(6'd4);
    check("R5 self loop", loop_o, 1);
    check("R5 self page", page_o, 4);
  endtask

  task automatic t_hop_limit();
    clear_mem();
    mem[9'h100 + 3] = ~8'd1;
    mem[9'h100 + 1] = ~8'd2;
    mem[9'h100 + 2] = ~8'd1;
    run(6'd3);
    check("R6 loop", loop_o, 1);
    check("R6 reads", reads, 64);
    check("R6 page", page_o, 1);
    check("R6 latency", lat, 2 * 64 + 3);
  endtask

  task automatic t_busy();
    clear_mem();
    mem[9'h100 + 10] = ~8'd20;
    mem[9'h100 + 20] = ~8'd33;
    mem[9'h100 + 12] = 8'h3F;
    @(negedge clk);
    page_i  = 6'd10;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    page_i  = 6'd12;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 4;
    while (!done_o && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check("R9 page", page_o, 33);
    check("R9 fault", fault_o, 0);
    check("R9 latency", lat, 2 * 3 + 3);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    redir_reads = 0;
    last_redir_addr = '0;
    rd_data_i = 8'hFF;
    start_i = 1'b0;
    page_i  = '0;
    rst_n   = 1'b0;
    clear_mem();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_chain();
    t_range();
    t_origin();
    t_hop_limit();
    t_busy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule